// File: doc/BRIEF.md
# Multi-Mode Effective Address Generator

This block forms the 16-bit memory address for operand accesses of an 8-bit CPU data path. A decoded mode code picks the address source. In indexed mode the address is one of two index registers plus a signed 8-bit offset. In pointer mode the address is a 16-bit pointer register, unchanged. The remaining codes cover immediate, register and implied operands, which make no memory access. The block holds the two index registers and the pointer register. A write port loads them.

An access begins with a one-cycle start strobe. The block answers on the next cycle with a registered address. For a 16-bit operand, the block issues the low byte at the base address. On the following cycle it issues the high byte at the base address plus one, and only then raises done. While that second byte is pending, the block ignores both the register write port and a new start.

Top module: `addr_gen`

## Requirements
- R1: After synchronous reset, `addr` is 0, `lo_valid`, `hi_valid` and `done` are 0, and all three address registers hold 0.
- R2: With `mode`=2 (indexed), the address issued is the selected index register plus the `disp` byte sign-extended, taken modulo 65536. Bytes 0x80..0xFF subtract 128..1. A zero offset gives the register value itself.
- R3: `idx_sel`=0 selects index register A and `idx_sel`=1 selects index register B. `wr_sel` 0, 1 and 2 load A, B and the pointer respectively. `wr_sel`=3 loads nothing.
- R4: With `mode`=1 (pointer), the address issued is the pointer register value unchanged.
- R5: With `mode`=0 or 3 (no memory operand), the cycle after start shows `done`=1, with `lo_valid` and `hi_valid` both 0.
- R6: A narrow access (`wide`=0) in mode 1 or 2 shows `lo_valid`=1 and `done`=1 together on the cycle after start, and neither on the cycle after that.
- R7: A wide access (`wide`=1) shows `lo_valid`=1 and `done`=0 at the base address on the cycle after start. On the next cycle it shows `hi_valid`=1 and `done`=1 at the base address plus one, wrapping 0xFFFF to 0x0000. `lo_valid` and `hi_valid` are never high together.
- R8: On the cycle the low byte of a wide access is shown, a register write and a start strobe have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register load strobe |
| wr_sel | input | 2 | Register to load: 0 index A, 1 index B, 2 pointer, 3 none |
| wr_data | input | AW | Value to load |
| start | input | 1 | Begin an access, one cycle |
| mode | input | 2 | 0 none, 1 pointer, 2 indexed, 3 none |
| idx_sel | input | 1 | Index register choice for indexed mode |
| disp | input | DW | Signed offset for indexed mode |
| wide | input | 1 | 1 for a two-byte operand |
| addr | output | AW | Registered memory address |
| lo_valid | output | 1 | Low or only byte address is valid |
| hi_valid | output | 1 | High byte address is valid |
| done | output | 1 | Access finished |

## Verification
The bench builds the block with its default widths: 16-bit addresses and an 8-bit offset. At these widths, every one of the 256 offset values can be applied to each of several index values placed at the wrap edges (0x0000, 0x007F, 0x8000, 0xFFFF). That covers wrap in both directions and the zero-offset case in full. Wide accesses at 0xFFFF reach the high-byte wrap. A write and a start issued during the pending high byte are checked for having no effect, by reading the registers back through ordinary accesses.

// File: rtl/eag_pkg.sv
package eag_pkg;
  localparam logic [1:0] MODE_NONE = 2'd0;
  localparam logic [1:0] MODE_PTR  = 2'd1;
  localparam logic [1:0] MODE_IDX  = 2'd2;
  localparam logic [1:0] MODE_RSVD = 2'd3;

  localparam logic [1:0] SEL_IDXA = 2'd0;
  localparam logic [1:0] SEL_IDXB = 2'd1;
  localparam logic [1:0] SEL_PTR  = 2'd2;

  function automatic logic is_mem(input logic [1:0] m);
    return (m == MODE_PTR) || (m == MODE_IDX);
  endfunction
endpackage

// File: rtl/eag_regs.sv
module eag_regs #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [1:0]    wr_sel,
  input  logic [AW-1:0] wr_data,
  input  logic          lock,
  output logic [AW-1:0] idx_a_q,
  output logic [AW-1:0] idx_b_q,
  output logic [AW-1:0] ptr_q
);
  import eag_pkg::*;

  localparam int NREG = 3;
  logic [AW-1:0] regs [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst)
        regs[g] <= '0;
      else if (wr_en && !lock && (wr_sel == 2'(g)))
        regs[g] <= wr_data;
    end
  end

  assign idx_a_q = regs[SEL_IDXA];
  assign idx_b_q = regs[SEL_IDXB];
  assign ptr_q   = regs[SEL_PTR];
endmodule

// File: rtl/eag_calc.sv
module eag_calc #(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic [1:0]    mode,
  input  logic          idx_sel,
  input  logic [DW-1:0] disp,
  input  logic [AW-1:0] idx_a_q,
  input  logic [AW-1:0] idx_b_q,
  input  logic [AW-1:0] ptr_q,
  output logic [AW-1:0] base,
  output logic          mem
);
  import eag_pkg::*;

  localparam int EXT = AW - DW;

  logic [AW-1:0] disp_ext;
  logic [AW-1:0] idx_val;

  assign disp_ext = {{EXT{disp[DW-1]}}, disp};
  assign idx_val  = idx_sel ? idx_b_q : idx_a_q;
  assign mem      = is_mem(mode);

  always_comb begin
    if (mode == MODE_IDX)
      base = idx_val + disp_ext;
    else
      base = ptr_q;
  end
endmodule

// File: rtl/eag_seq.sv
module eag_seq #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          mem,
  input  logic          wide,
  input  logic [AW-1:0] base,
  output logic [AW-1:0] addr,
  output logic          lo_valid,
  output logic          hi_valid,
  output logic          done,
  output logic          busy
);
  always_ff @(posedge clk) begin
    if (rst) begin
      addr     <= '0;
      lo_valid <= 1'b0;
      hi_valid <= 1'b0;
      done     <= 1'b0;
      busy     <= 1'b0;
    end else begin
      lo_valid <= 1'b0;
      hi_valid <= 1'b0;
      done     <= 1'b0;
      if (busy) begin
        addr     <= addr + AW'(1);
        hi_valid <= 1'b1;
        done     <= 1'b1;
        busy     <= 1'b0;
      end else if (start) begin
        if (mem) begin
          addr     <= base;
          lo_valid <= 1'b1;
          done     <= !wide;
          busy     <= wide;
        end else begin
          done <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/addr_gen.sv
module addr_gen #(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [1:0]    wr_sel,
  input  logic [AW-1:0] wr_data,
  input  logic          start,
  input  logic [1:0]    mode,
  input  logic          idx_sel,
  input  logic [DW-1:0] disp,
  input  logic          wide,
  output logic [AW-1:0] addr,
  output logic          lo_valid,
  output logic          hi_valid,
  output logic          done
);
  logic [AW-1:0] idx_a_q, idx_b_q, ptr_q, base;
  logic          mem, seq_busy;

  eag_regs #(.AW(AW)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .lock(seq_busy),
    .idx_a_q(idx_a_q), .idx_b_q(idx_b_q), .ptr_q(ptr_q)
  );

  eag_calc #(.AW(AW), .DW(DW)) u_calc (
    .mode(mode), .idx_sel(idx_sel), .disp(disp),
    .idx_a_q(idx_a_q), .idx_b_q(idx_b_q), .ptr_q(ptr_q),
    .base(base), .mem(mem)
  );

  eag_seq #(.AW(AW)) u_seq (
    .clk(clk), .rst(rst), .start(start), .mem(mem), .wide(wide),
    .base(base), .addr(addr), .lo_valid(lo_valid),
    .hi_valid(hi_valid), .done(done), .busy(seq_busy)
  );
endmodule

// File: rtl/eag_chk.sv
module eag_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          start,
  input logic [1:0]    mode,
  input logic          wide,
  input logic          busy,
  input logic [AW-1:0] idx_a_q,
  input logic [AW-1:0] idx_b_q,
  input logic [AW-1:0] ptr_q,
  input logic [AW-1:0] addr,
  input logic          lo_valid,
  input logic          hi_valid,
  input logic          done
);
  // R7
  hi_step_chk: assert property (@(posedge clk) disable iff (rst)
    (lo_valid && !done) |=> (hi_valid && done && addr == $past(addr) + AW'(1)));

  // R7
  byte_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(lo_valid && hi_valid));

  // R6
  narrow_done_chk: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && (mode == 2'd1 || mode == 2'd2) && !wide)
      |=> (lo_valid && done && !hi_valid));

  // R5
  no_mem_chk: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && (mode == 2'd0 || mode == 2'd3))
      |=> (done && !lo_valid && !hi_valid));

  // R4
  ptr_addr_chk: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && mode == 2'd1) |=> (addr == $past(ptr_q)));

  // R8
  wr_lock_chk: assert property (@(posedge clk) disable iff (rst)
    busy |=> ($stable(ptr_q) && $stable(idx_a_q) && $stable(idx_b_q)));
endmodule

bind addr_gen eag_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst(rst), .start(start), .mode(mode), .wide(wide),
  .busy(seq_busy), .idx_a_q(idx_a_q), .idx_b_q(idx_b_q), .ptr_q(ptr_q),
  .addr(addr), .lo_valid(lo_valid), .hi_valid(hi_valid), .done(done)
);

// File: tb/addr_gen_bench.sv
module addr_gen_bench;
  localparam int AW = 16;
  localparam int DW = 8;
  localparam time CLK_PERIOD = 10ns;
  localparam int WATCHDOG = 100000;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en = 1'b0;
  logic [1:0]    wr_sel = '0;
  logic [AW-1:0] wr_data = '0;
  logic          start = 1'b0;
  logic [1:0]    mode = '0;
  logic          idx_sel = 1'b0;
  logic [DW-1:0] disp = '0;
  logic          wide = 1'b0;
  logic [AW-1:0] addr;
  logic          lo_valid, hi_valid, done;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  addr_gen #(.AW(AW), .DW(DW)) u_addr_gen (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .start(start), .mode(mode), .idx_sel(idx_sel), .disp(disp), .wide(wide),
    .addr(addr), .lo_valid(lo_valid), .hi_valid(hi_valid), .done(done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > WATCHDOG) begin
      errors = errors + 1;
      $display("FAIL watchdog: actual %0d cycles expected under %0d", cycles, WATCHDOG);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic load(input logic [1:0] sel, input logic [AW-1:0] val);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = val;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  function automatic logic [AW-1:0] offs(input logic [AW-1:0] v, input logic [DW-1:0] d);
    int s;
    s = d[DW-1] ? int'(d) - 256 : int'(d);
    return AW'((int'(v) + s + 65536) % 65536);
  endfunction

  // one access; checks the response cycle(s)
  task automatic access(input logic [1:0] m, input logic sel, input logic [DW-1:0] d,
                        input logic w, input logic [AW-1:0] exp, input string req);
    bit mem_op;
    mem_op = (m == 2'd1) || (m == 2'd2);
    @(negedge clk);
    start = 1'b1; mode = m; idx_sel = sel; disp = d; wide = w;
    @(negedge clk);
    start = 1'b0;
    chk(lo_valid == mem_op, req, lo_valid, mem_op);
    chk(done == (!mem_op || !w), req, done, !mem_op || !w);
    chk(hi_valid == 1'b0, req, hi_valid, 0);
    if (mem_op) chk(addr == exp, req, addr, exp);
    if (mem_op && w) begin
      @(negedge clk);
      chk(hi_valid && done && !lo_valid, req, {hi_valid, done, lo_valid}, 3'b110);
      chk(addr == exp + AW'(1), req, addr, exp + AW'(1));
    end
  endtask

  initial begin
    logic [AW-1:0] vals [4];
    vals[0] = 16'h0000; vals[1] = 16'h007F; vals[2] = 16'h8000; vals[3] = 16'hFFFF;

    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: outputs and registers at zero
    chk(addr == 0 && !lo_valid && !hi_valid && !done, "R1", {addr, lo_valid, hi_valid, done}, 0);
    access(2'd1, 1'b0, 8'h00, 1'b0, 16'h0000, "R1");
    access(2'd2, 1'b1, 8'h00, 1'b0, 16'h0000, "R1");

    // R2/R3: full offset sweep on both index registers
    foreach (vals[i]) begin
      load(2'd0, vals[i]);
      load(2'd1, ~vals[i]);
      for (int d = 0; d < 256; d++) begin
        access(2'd2, 1'b0, 8'(d), 1'b0, offs(vals[i], 8'(d)), "R2");
        access(2'd2, 1'b1, 8'(d), 1'b0, offs(~vals[i], 8'(d)), "R3");
      end
    end

    // R4: pointer mode; zero offset indexed matches
    load(2'd2, 16'h1234);
    load(2'd0, 16'h1234);
    access(2'd1, 1'b0, 8'h55, 1'b0, 16'h1234, "R4");
    access(2'd2, 1'b0, 8'h00, 1'b0, 16'h1234, "R2");

    // R3: wr_sel 3 writes nothing
    load(2'd3, 16'hBEEF);
    access(2'd1, 1'b0, 8'h00, 1'b0, 16'h1234, "R3");
    access(2'd2, 1'b0, 8'h00, 1'b0, 16'h1234, "R3");
    access(2'd2, 1'b1, 8'h00, 1'b0, 16'h0000, "R3");

    // R5: non-memory modes
    access(2'd0, 1'b0, 8'h00, 1'b0, 16'h0, "R5");
    access(2'd3, 1'b0, 8'h00, 1'b1, 16'h0, "R5");

    // R6: narrow, then silence the next cycle
    access(2'd1, 1'b0, 8'h00, 1'b0, 16'h1234, "R6");
    @(negedge clk);
    chk(!lo_valid && !hi_valid && !done, "R6", {lo_valid, hi_valid, done}, 0);

    // R7: wide accesses including high-byte wrap
    load(2'd2, 16'hFFFF);
    access(2'd1, 1'b0, 8'h00, 1'b1, 16'hFFFF, "R7");
    load(2'd0, 16'h0010);
    access(2'd2, 1'b0, 8'hF0, 1'b1, 16'h0000, "R7");
    access(2'd2, 1'b0, 8'hEF, 1'b1, 16'hFFFF, "R7");

    // R8: write and start on the low-byte cycle are ignored
    load(2'd2, 16'h4000);
    @(negedge clk);
    start = 1'b1; mode = 2'd1; wide = 1'b1;
    @(negedge clk);
    chk(lo_valid && addr == 16'h4000, "R8", addr, 16'h4000);
    mode = 2'd0; wide = 1'b0;
    wr_en = 1'b1; wr_sel = 2'd2; wr_data = 16'h9999;
    @(negedge clk);
    start = 1'b0; wr_en = 1'b0;
    chk(hi_valid && done && addr == 16'h4001, "R8", addr, 16'h4001);
    @(negedge clk);
    chk(!lo_valid && !hi_valid && !done, "R8", {lo_valid, hi_valid, done}, 0);
    access(2'd1, 1'b0, 8'h00, 1'b0, 16'h4000, "R8");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule